// File: doc/BRIEF.md
# Rank-Programmable Dual Butterfly Delay Line

This block holds the two delay lines that one stage of a 32-point pipelined number-theoretic transform needs around its butterfly. A single part can act as any stage of a forward or an inverse pipeline. A 3-bit stage index and a direction bit pick the length of each delay from a fixed table. The two delays carry 17-bit words. Neither selects an output tap. Each is a series chain of five stage groups holding 8, 4, 2, 1 and 1 registers. A decoder switches every group either to store its data or to pass it straight through, so a chain with every group bypassed is a plain wire.

Stored data moves forward only on clock edges where the advance enable is high. In the full stage this enable comes from the toggle that multiplexes the data pins, so it is high on every other cycle. Holding it low freezes every stored word. Stage index and direction are meant to stay fixed while the block runs and to change only under reset. Reset is asynchronous and active low, and the block releases it internally on a clock edge.

Top module: `fnt_dly_pair`

## Requirements
- R1: With `inv_dir` = 0 (forward), line A delays by 16, 8, 4, 2 and 1 enabled edges for `rank` 0, 1, 2, 3 and 4. After enabled edge n, `a_out` equals the `a_in` sampled at enabled edge n−L+1, where L is the length.
- R2: With `inv_dir` = 0, line B delays by 8, 4, 2, 1 and 0 enabled edges for `rank` 0 to 4, following the same timing rule.
- R3: With `inv_dir` = 1 (inverse), line A delays by 0, 1, 2, 4 and 8 enabled edges for `rank` 0 to 4.
- R4: With `inv_dir` = 1, line B delays by 1, 2, 4, 8 and 16 enabled edges for `rank` 0 to 4.
- R5: A line of length zero is combinational. Its output equals its input in the same cycle, whatever the state of `adv_en`.
- R6: On cycles with `adv_en` low, no stored word changes, so a line of nonzero length keeps its output steady while its input changes.
- R7: `rank` values 5, 6 and 7 are illegal and give both lines a length of zero.
- R8: Reset clears every stored word to zero. Before data reaches the end of a line of nonzero length, that line outputs 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on a clock edge |
| adv_en | input | 1 | Advance enable; stored data moves only when it is high |
| rank | input | 3 | Pipeline stage index, 0 to 4 legal |
| inv_dir | input | 1 | 0 forward transform, 1 inverse transform |
| a_in | input | 17 | Line A data in |
| a_out | output | 17 | Line A data out |
| b_in | input | 17 | Line B data in |
| b_out | output | 17 | Line B data out |

## Verification
Two functions can land in the same cycle: the combinational bypass of a zero-length line and the hold of the other line while `adv_en` is low. Forward rank 4 and inverse rank 0 each pair a zero-length line with a one-stage line. In those settings the bench changes both inputs on every disabled cycle. It then judges each output against its own model. The zero-length output must follow its new input at once. The other output must keep the word it held on the last enabled edge.

// File: rtl/fnt_dly_pkg.sv
package fnt_dly_pkg;

  localparam int unsigned NGRP     = 5;
  localparam int unsigned RANK_W   = 3;
  localparam int unsigned MAX_RANK = 4;

  typedef logic [NGRP-1:0] grp_mask_t;

  // register count of group g: 8, 4, 2, 1, 1
  function automatic int unsigned grp_depth(input int unsigned g);
    return (g < 3) ? (8 >> g) : 1;
  endfunction

  // delay length in enabled edges for a line (second = 0: line A, 1: line B)
  function automatic int unsigned dly_len(input logic [RANK_W-1:0] rk,
                                          input logic inv, input logic second);
    int unsigned base;
    if (rk > RANK_W'(MAX_RANK)) return 0;
    if (!inv) base = 16 >> rk;
    else      base = 1 << rk;
    if (second != inv) return base >> 1;
    return base;
  endfunction

  // groups that store for a given length
  function automatic grp_mask_t len_to_mask(input int unsigned len);
    grp_mask_t m;
    if (len >= 16) return '1;
    m[0] = len[3];
    m[1] = len[2];
    m[2] = len[1];
    m[3] = len[0];
    m[4] = 1'b0;
    return m;
  endfunction

  // stored length of a mask
  function automatic int unsigned mask_weight(input grp_mask_t m);
    int unsigned w;
    w = 0;
    for (int g = 0; g < NGRP; g++) if (m[g]) w += grp_depth(g);
    return w;
  endfunction

endpackage

// File: rtl/fnt_dly_decode.sv
module fnt_dly_decode
  import fnt_dly_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RANK_W-1:0] rank,
  input  logic              inv_dir,
  output grp_mask_t         mask_a,
  output grp_mask_t         mask_b
);

  always_comb begin
    mask_a = len_to_mask(dly_len(rank, inv_dir, 1'b0));
    mask_b = len_to_mask(dly_len(rank, inv_dir, 1'b1));
  end

  logic legal;
  assign legal = (rank <= RANK_W'(MAX_RANK));

  AST_FWD_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (legal && !inv_dir && rank != RANK_W'(MAX_RANK)) |->
      (mask_weight(mask_a) == 2 * mask_weight(mask_b)))
    else $error("forward B not half of A"); // R2

  AST_INV_DOUBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (legal && inv_dir && rank != '0) |->
      (mask_weight(mask_b) == 2 * mask_weight(mask_a)))
    else $error("inverse B not double A"); // R4

  AST_END_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (legal && ((!inv_dir && rank == RANK_W'(MAX_RANK)) || (inv_dir && rank == '0))) |->
      (mask_weight(inv_dir ? mask_a : mask_b) == 0))
    else $error("end rank not zero length"); // R3

  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !legal |-> (mask_a == '0 && mask_b == '0))
    else $error("illegal rank gives nonzero delay"); // R7

endmodule

// File: rtl/fnt_dly_group.sv
module fnt_dly_group #(
  parameter int unsigned DATA_W = 17,
  parameter int unsigned DEPTH  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_en,
  input  logic              active,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);

  logic [DATA_W-1:0] sr_q [DEPTH];
  logic [DATA_W-1:0] sr_d [DEPTH];
  logic              step;

  assign step = adv_en & active;

  always_comb begin
    sr_d[0] = d;
    for (int i = 1; i < DEPTH; i++) sr_d[i] = sr_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) sr_q[i] <= '0;
    end else if (step) begin
      sr_q <= sr_d;
    end
  end

  assign q = active ? sr_q[DEPTH-1] : d;

  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_en |=> $stable(sr_q[DEPTH-1]))
    else $error("stored word moved while frozen"); // R6

  AST_LOAD_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (sr_q[0] == $past(d)))
    else $error("head register missed input"); // R1

endmodule

// File: rtl/fnt_dly_chain.sv
module fnt_dly_chain
  import fnt_dly_pkg::*;
#(
  parameter int unsigned DATA_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_en,
  input  grp_mask_t         mask,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  logic [DATA_W-1:0] link [NGRP+1];

  assign link[0] = din;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    fnt_dly_group #(
      .DATA_W (DATA_W),
      .DEPTH  (grp_depth(g))
    ) grp_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv_en (adv_en),
      .active (mask[g]),
      .d      (link[g]),
      .q      (link[g+1])
    );
  end

  assign dout = link[NGRP];

  AST_ZERO_WIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> (dout == din))
    else $error("zero-length line not transparent"); // R5

endmodule

// File: rtl/fnt_dly_pair.sv
module fnt_dly_pair
  import fnt_dly_pkg::*;
#(
  parameter int unsigned DATA_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_en,
  input  logic [RANK_W-1:0] rank,
  input  logic              inv_dir,
  input  logic [DATA_W-1:0] a_in,
  output logic [DATA_W-1:0] a_out,
  input  logic [DATA_W-1:0] b_in,
  output logic [DATA_W-1:0] b_out
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  grp_mask_t  mask_a;
  grp_mask_t  mask_b;

  // asynchronous assert, clocked release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  fnt_dly_decode dec_i (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .rank    (rank),
    .inv_dir (inv_dir),
    .mask_a  (mask_a),
    .mask_b  (mask_b)
  );

  fnt_dly_chain #(.DATA_W(DATA_W)) line_a_i (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .adv_en (adv_en),
    .mask   (mask_a),
    .din    (a_in),
    .dout   (a_out)
  );

  fnt_dly_chain #(.DATA_W(DATA_W)) line_b_i (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .adv_en (adv_en),
    .mask   (mask_b),
    .din    (b_in),
    .dout   (b_out)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_int_n |=> (mask_a == '0 || a_out == '0 || !rst_int_n || $past(adv_en)))
    else $error("line A not cleared by reset"); // R8

endmodule

// File: tb/fnt_dly_pair_tb.sv
`timescale 1ns/1ps
module fnt_dly_pair_tb_top;

  localparam int DW = 17;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          adv_en;
  logic [2:0]    rank;
  logic          inv_dir;
  logic [DW-1:0] a_in, b_in, a_out, b_out;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  fnt_dly_pair dut_i (
    .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .rank(rank), .inv_dir(inv_dir),
    .a_in(a_in), .a_out(a_out), .b_in(b_in), .b_out(b_out)
  );

  // {rank, inv_dir, length A, length B}
  localparam logic [13:0] VEC [13] = '{
    {3'd0, 1'b0, 5'd16, 5'd8},  {3'd1, 1'b0, 5'd8, 5'd4},
    {3'd2, 1'b0, 5'd4,  5'd2},  {3'd3, 1'b0, 5'd2, 5'd1},
    {3'd4, 1'b0, 5'd1,  5'd0},  {3'd0, 1'b1, 5'd0, 5'd1},
    {3'd1, 1'b1, 5'd1,  5'd2},  {3'd2, 1'b1, 5'd2, 5'd4},
    {3'd3, 1'b1, 5'd4,  5'd8},  {3'd4, 1'b1, 5'd8, 5'd16},
    {3'd5, 1'b0, 5'd0,  5'd0},  {3'd6, 1'b1, 5'd0, 5'd0},
    {3'd7, 1'b0, 5'd0,  5'd0}
  };

  logic [DW-1:0] ha [64];
  logic [DW-1:0] hb [64];

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] rk, input logic dr);
    rst_n = 1'b0; adv_en = 1'b0; rank = rk; inv_dir = dr;
    a_in = '0; b_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [DW-1:0] model(input int len, input int n,
                                          input logic [DW-1:0] cur, input logic [DW-1:0] h [64]);
    int idx;
    if (len == 0) return cur;
    idx = n - len + 1;
    return (idx >= 1) ? h[idx] : '0;
  endfunction

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // table walk over every rank and direction
    for (int v = 0; v < 13; v++) begin
      logic [2:0] rk; logic dr; int la, lb, n;
      string ta, tb;
      rk = VEC[v][13:11]; dr = VEC[v][10];
      la = int'(VEC[v][9:5]); lb = int'(VEC[v][4:0]);
      do_reset(rk, dr);
      n = 0;
      // R8: reset state before any advance
      check(la == 0 ? "R5" : "R8", a_out, la == 0 ? a_in : '0);
      check(lb == 0 ? "R5" : "R8", b_out, lb == 0 ? b_in : '0);
      if (rk > 3'd4) begin ta = "R7"; tb = "R7"; end
      else begin
        ta = (la == 0) ? "R5" : (dr ? "R3" : "R1");
        tb = (lb == 0) ? "R5" : (dr ? "R4" : "R2");
      end
      for (int c = 0; c < 48; c++) begin
        if (c > 0) begin
          check(ta, a_out, model(la, n, a_in, ha));
          check(tb, b_out, model(lb, n, b_in, hb));
        end
        adv_en = (c % 2 == 0);
        if (adv_en) begin
          a_in = DW'(v * 1000 + c * 7 + 1);
          b_in = a_in ^ 17'h0F0F0;
          n++;
          ha[n] = a_in; hb[n] = b_in;
        end else begin
          // R6: junk on disabled cycles must not enter
          a_in = 17'h1ABCD ^ DW'(c);
          b_in = 17'h05A5A ^ DW'(c * 3);
        end
        @(negedge clk);
      end
    end

    // directed R6: long freeze on forward rank 1 (A = 8, B = 4)
    begin
      logic [DW-1:0] hold_a, hold_b;
      do_reset(3'd1, 1'b0);
      for (int c = 0; c < 10; c++) begin
        adv_en = 1'b1; a_in = DW'(c + 100); b_in = DW'(c + 200);
        @(negedge clk);
      end
      check("R1", a_out, DW'(102));
      check("R2", b_out, DW'(206));
      hold_a = a_out; hold_b = b_out;
      for (int c = 0; c < 8; c++) begin
        adv_en = 1'b0; a_in = DW'(c * 911); b_in = DW'(c * 517);
        @(negedge clk);
        check("R6", a_out, hold_a);
        check("R6", b_out, hold_b);
      end
    end

    // directed R8: mid-run reset clears the stored words
    begin
      do_reset(3'd4, 1'b1);
      check("R8", a_out, '0);
      check("R8", b_out, '0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule